// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder with Bubble Suppression

This block is the digital back end of a 6-bit flash converter. Each clock it takes the 63-bit thermometer word from the comparator bank. It locates the point where the run of ones ends and marks it on one of 64 edge lines. A three-input gate rule drops a stray comparator that reads high above that point. The line set then passes through an OR-tree encoder, which gives the 6-bit sample code. All of this is plain gates with no lookup storage, and a new code can start on every clock.

The comparator word is registered on one rising edge. The edge lines and the encoding are evaluated during the next cycle, and the code, a valid flag and an error flag are registered on the following edge. If more than one edge line survives the gate rule, the code is the bitwise OR of the active line indices and the error flag marks that sample.

Top module: `therm_bin_encoder`

## Requirements
- R1: While `rst_n` is low at a rising edge, the registers are cleared: after that edge `code_out` is 0, `vld_out` is 0 and `err_out` is 0.
- R2: After `rst_n` returns high, `vld_out` stays 0 through the first rising edge, goes to 1 on the second rising edge, and then stays 1 until the next reset.
- R3: A word present on `therm_in` at rising edge N produces its `code_out` and `err_out` right after rising edge N+1. Words applied on consecutive cycles give codes on consecutive cycles.
- R4: Bit j of `therm_in` is comparator j. Edge line i (0..63) is active when bit i-1 and bit i-2 are 1 and bit i is 0. Bits below index 0 count as 1 and bit 63 counts as 0. For a clean word with bits 0..k-1 set and the rest clear, `code_out` equals k, for every k from 0 to 63.
- R5: An all-zero word gives code 0 and an all-one word gives code 63, both with `err_out` at 0.
- R6: A single stray 1 above the edge is suppressed. This holds when bits 0..k-1 are set, bit k is clear, and one bit at position k+1 or higher is set with its neighbours clear. The result is code k with `err_out` at 0.
- R7: When two or more edge lines are active, such as for a cleared bit inside the run of ones, `code_out` is the bitwise OR of the active line indices and `err_out` is 1 for that sample.
- R8: `err_out` returns to 0 for the next sample that leaves exactly one edge line active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| therm_in | input | 63 | Comparator outputs, bit j from comparator j |
| code_out | output | 6 | Registered binary sample code |
| vld_out | output | 1 | Code is meaningful (pipeline filled since reset) |
| err_out | output | 1 | More than one edge line was active for this code |

## Verification
Every code and error flag is due exactly one rising edge after the edge that captures its input word, so it lands two edges after the word is driven. The bench drives on the falling edge and checks on a later falling edge, after waiting exactly those two rising edges. In the streaming scenario a new word is driven on every falling edge, and the value checked at falling edge j is the word driven at falling edge j-2. This proves one code per clock. The valid flag is checked after the first and after the second rising edge following reset release, to pin down when it rises.

// File: rtl/therm_pkg.sv
// Package: shared sizing for the thermometer encoder.
// Assumes the code width is small enough that 2**CODE_W lines are practical.
package therm_pkg;
    localparam int CODE_W_DEF = 6;

    // Number of edge lines for a given code width.
    function automatic int lines_of(input int code_w);
        return 1 << code_w;
    endfunction
endpackage

// File: rtl/therm_edge_detect.sv
// Edge detector: turns a thermometer word into edge lines using a three-input
// rule (two ones below, a zero at the position). Bits below index 0 read as 1,
// the bit above the top reads as 0. A stray single 1 above the edge is dropped.
// Assumes THERM_W = LINES - 1.
module therm_edge_detect #(
    parameter int LINES = 64
) (
    input  logic [LINES-2:0] therm,
    output logic [LINES-1:0] hot
);
    localparam int THERM_W = LINES - 1;
    localparam int EXT_W   = LINES + 2;

    logic [EXT_W-1:0] ext;

    // Pad the word: two implied ones below, one implied zero on top.
    assign ext = {1'b0, therm, 2'b11};

    for (genvar i = 0; i < LINES; i++) begin : g_line
        // Line i: t[i-2] & t[i-1] & ~t[i], padded indices shifted by two.
        assign hot[i] = ext[i] & ext[i+1] & ~ext[i+2];
    end
endmodule

// File: rtl/onehot_fat_tree_enc.sv
// Fat-tree encoder: each code bit is an OR tree over the lines whose index
// has that bit set. With several lines active, the result is the OR of their
// indices. Assumes LINES is a power of two.
module onehot_fat_tree_enc #(
    parameter int CODE_W = 6
) (
    input  logic [(1<<CODE_W)-1:0] hot,
    output logic [CODE_W-1:0]      code
);
    localparam int LINES = 1 << CODE_W;
    localparam int NODES = 2 * LINES - 1;

    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        logic [NODES-1:0] node;
        for (genvar i = 0; i < LINES; i++) begin : g_leaf
            if (((i >> b) & 1) == 1) begin : g_on
                assign node[LINES-1+i] = hot[i];
            end else begin : g_off
                assign node[LINES-1+i] = 1'b0;
            end
        end
        for (genvar k = 0; k < LINES - 1; k++) begin : g_or
            // Two-input OR node of the tree.
            assign node[k] = node[2*k+1] | node[2*k+2];
        end
        assign code[b] = node[0];
    end
endmodule

// File: rtl/onehot_multi_detect.sv
// Multi-hot detector: a binary tree that tracks, per subtree, whether any line
// is set and whether two or more are set. Assumes LINES is a power of two.
module onehot_multi_detect #(
    parameter int LINES = 64
) (
    input  logic [LINES-1:0] hot,
    output logic             multi
);
    localparam int NODES = 2 * LINES - 1;

    logic [NODES-1:0] any_n;
    logic [NODES-1:0] mul_n;

    for (genvar i = 0; i < LINES; i++) begin : g_leaf
        assign any_n[LINES-1+i] = hot[i];
        assign mul_n[LINES-1+i] = 1'b0;
    end
    for (genvar k = 0; k < LINES - 1; k++) begin : g_node
        // Merge two subtrees: multiple if either is, or both have one.
        assign any_n[k] = any_n[2*k+1] | any_n[2*k+2];
        assign mul_n[k] = mul_n[2*k+1] | mul_n[2*k+2] | (any_n[2*k+1] & any_n[2*k+2]);
    end
    assign multi = mul_n[0];
endmodule

// File: rtl/therm_bin_encoder.sv
// Top: registers the comparator word, finds edge lines, encodes them through
// a fat OR tree and registers code, valid and error flags. Two-edge latency,
// one code per clock. Assumes a synchronous, active-low reset.
module therm_bin_encoder #(
    parameter int CODE_W = therm_pkg::CODE_W_DEF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [(1<<CODE_W)-2:0]       therm_in,
    output logic [CODE_W-1:0]            code_out,
    output logic                         vld_out,
    output logic                         err_out
);
    localparam int LINES   = therm_pkg::lines_of(CODE_W);
    localparam int THERM_W = LINES - 1;

    logic [THERM_W-1:0] therm_q;
    logic               vld_q;
    logic [LINES-1:0]   hot;
    logic [CODE_W-1:0]  code_nxt;
    logic               multi;

    // Stage 1: capture the comparator word and start the valid chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            therm_q <= '0;
            vld_q   <= 1'b0;
        end else begin
            therm_q <= therm_in;
            vld_q   <= 1'b1;
        end
    end

    therm_edge_detect #(.LINES(LINES)) u_edge (
        .therm (therm_q),
        .hot   (hot)
    );

    onehot_fat_tree_enc #(.CODE_W(CODE_W)) u_enc (
        .hot  (hot),
        .code (code_nxt)
    );

    onehot_multi_detect #(.LINES(LINES)) u_multi (
        .hot   (hot),
        .multi (multi)
    );

    // Stage 2: register code, error and valid outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out <= '0;
            err_out  <= 1'b0;
            vld_out  <= 1'b0;
        end else begin
            code_out <= code_nxt;
            err_out  <= multi;
            vld_out  <= vld_q;
        end
    end

    AST_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_q == '0) |=> (code_out == '0 && !err_out)); // R5
    AST_ALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (&therm_q) |=> (code_out == '1 && !err_out)); // R5
    AST_CLEAN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ((therm_q & (therm_q + 1'b1)) == '0) |=> (code_out == CODE_W'($countones($past(therm_q))))); // R4
    AST_MULTI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(hot) > 1) |=> err_out); // R7
    AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(hot) |=> !err_out); // R8
    AST_VLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        vld_out |=> vld_out); // R2
endmodule

// File: tb/sim_therm_bin_encoder.sv
`timescale 1ns/1ps
module sim_therm_bin_encoder;
    localparam int CW = 6;
    localparam int TW = 63;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] therm_in = '0;
    logic [CW-1:0] code_out;
    logic          vld_out;
    logic          err_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    therm_bin_encoder #(.CODE_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .therm_in(therm_in),
        .code_out(code_out), .vld_out(vld_out), .err_out(err_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] clean(input int k);
        logic [TW-1:0] v = '0;
        for (int j = 0; j < k; j++) v[j] = 1'b1;
        return v;
    endfunction

    // Apply one word and check it after the two rising edges it needs.
    task automatic one(input logic [TW-1:0] w, input int exp_code, input int exp_err, input string req);
        @(negedge clk);
        therm_in = w;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check({req, " code"}, code_out, exp_code);
        check({req, " err"}, err_out, exp_err);
    endtask

    task automatic t_reset_valid();
        @(negedge clk);
        therm_in = '1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 code", code_out, 0);
        check("R1 vld", vld_out, 0);
        check("R1 err", err_out, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2 vld after first edge", vld_out, 0);
        @(posedge clk);
        @(negedge clk);
        check("R2 vld after second edge", vld_out, 1);
        @(posedge clk);
        @(negedge clk);
        check("R2 vld held", vld_out, 1);
    endtask

    task automatic t_ends();
        one('0, 0, 0, "R5 zeros");
        one('1, 63, 0, "R5 ones");
    endtask

    // R3 R4: stream every clean level back to back, one per clock.
    task automatic t_stream();
        int exp_q [$];
        for (int j = 0; j < 66; j++) begin
            @(negedge clk);
            if (j >= 2) check("R3 R4 stream code", code_out, exp_q.pop_front());
            if (j < 64) begin
                therm_in = clean(j);
                exp_q.push_back(j);
            end
        end
        check("R3 stream err", err_out, 0);
    endtask

    task automatic t_bubble_high();
        logic [TW-1:0] w;
        w = clean(10); w[11] = 1'b1;
        one(w, 10, 0, "R6 stray adjacent");
        w = clean(10); w[40] = 1'b1;
        one(w, 10, 0, "R6 stray far");
        w = clean(5); w[62] = 1'b1;
        one(w, 5, 0, "R6 stray top bit");
        w = '0; w[1] = 1'b1;
        one(w, 0, 0, "R6 stray over zero");
    endtask

    task automatic t_multi();
        logic [TW-1:0] w;
        w = clean(21); w[15] = 1'b0;
        one(w, 15 | 21, 1, "R7 hole in run");
        w = '1; w[0] = 1'b0;
        one(w, 0 | 63, 1, "R7 low hole all ones");
        one(clean(33), 33, 0, "R8 err clears");
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        t_reset_valid();
        t_ends();
        t_stream();
        t_bubble_high();
        t_multi();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule